// File: doc/BRIEF.md
# Bit-Configurable Parallel I/O Port

The block is a memory-mapped general-purpose I/O port. It has a 16-pin main port and a 4-pin auxiliary port. Each pin gets a 2-bit direction code in its port's control register. One code selects input, two codes select output, and the remaining code leaves the pin inactive. Each port also has a data register. A write to the data register updates the output latch, but only for pins that are currently outputs.

A read of a data register returns a merged view: sampled pin levels for input pins, latched values for output pins, and zero for inactive pins. A rewrite of a control register rebuilds the output latch from the last value written to the data register, masked by the new output set. Pad output enables follow the output set directly.

Register access uses one write strobe and a combinational read port, so an access completes in a single cycle.

Top module: `pio_port`

## Requirements
- R1: After reset, both control registers and both data views read 0, and every pin output and output enable is 0.
- R2: In a control register, pin i is governed by bits [2i+1:2i]. The control register reads back the value last written to its implemented bits. The main port implements bits [31:0] and the auxiliary port implements bits [7:0]. Upper bits read 0.
- R3: Direction code 2'b10 makes a pin an input. Its data-read bit equals the current pin input level, and its output enable is 0.
- R4: Direction codes 2'b01 and 2'b11 make a pin an output. Its output enable is 1 from the cycle after the control write.
- R5: Direction code 2'b00 makes a pin inactive. Its data-read bit is 0 whatever the pin input, and its output enable and output are 0.
- R6: A data write sets each output pin's latch to the written bit, from the next cycle. Latch bits of non-output pins become 0.
- R7: A data read returns (pin inputs AND input mask) OR (output latch AND output mask). Bits above the port width read 0.
- R8: A control write rebuilds the output latch as the last written data value ANDed with the new output mask.
- R9: The auxiliary port (4 pins) follows R2 to R8 with its own registers.
- R10: Offsets are 0x0 main control, 0x4 main data, 0x8 auxiliary control and 0xC auxiliary data. Any other address reads 0, and a write to it changes nothing.
- R11: Each port's output-enable vector equals its output mask, and no pin drives a 1 while its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| main_pin_in | input | 16 | Main port pin levels |
| main_pin_out | output | 16 | Main port output latch |
| main_pin_oe | output | 16 | Main port output enables |
| aux_pin_in | input | 4 | Auxiliary port pin levels |
| aux_pin_out | output | 4 | Auxiliary port output latch |
| aux_pin_oe | output | 4 | Auxiliary port output enables |

## Verification
The assertions assume that addr is stable whenever rdata is judged, and that the internal reset has been released before the first write counts. The bench holds its address and write strobe steady across each clock edge and changes them only at the falling edge. It waits several cycles after reset release before the first access. Random pin levels and random direction fields are applied only between writes, so each read and each output check sees settled stimulus.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {
    PIO_OFF     = 2'b00,
    PIO_OUT     = 2'b01,
    PIO_IN      = 2'b10,
    PIO_OUT_ALT = 2'b11
  } pio_dir_e;

  localparam int OFF_MAIN_CTRL = 'h0;
  localparam int OFF_MAIN_DATA = 'h4;
  localparam int OFF_AUX_CTRL  = 'h8;
  localparam int OFF_AUX_DATA  = 'hC;

  function automatic logic dir_is_out(input logic [1:0] code);
    return (code == PIO_OUT) || (code == PIO_OUT_ALT);
  endfunction

  function automatic logic dir_is_in(input logic [1:0] code);
    return code == PIO_IN;
  endfunction
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic [3:0]        sel,
  output logic [3:0]        we
);
  import pio_pkg::*;

  localparam int NREG = 4;
  localparam logic [ADDR_W-1:0] OFFS [NREG] = '{
    ADDR_W'(OFF_MAIN_CTRL), ADDR_W'(OFF_MAIN_DATA),
    ADDR_W'(OFF_AUX_CTRL),  ADDR_W'(OFF_AUX_DATA)
  };

  for (genvar r = 0; r < NREG; r++) begin : g_sel
    assign sel[r] = (addr == OFFS[r]);
    assign we[r]  = sel[r] & wr_en;
  end
endmodule

// File: rtl/pio_lane.sv
module pio_lane #(
  parameter int W  = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  pin_in,
  output logic [2*W-1:0] ctrl_val,
  output logic [W-1:0]  rd_val,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);
  import pio_pkg::*;

  localparam int CW = 2 * W;

  logic [CW-1:0] ctrl_q, ctrl_d;
  logic [W-1:0]  stored_q, stored_d;
  logic [W-1:0]  latch_q, latch_d;
  logic [W-1:0]  out_cur, in_cur, out_new;
  logic          upd_en;

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign out_cur[g] = dir_is_out(ctrl_q[2*g +: 2]);
    assign in_cur[g]  = dir_is_in(ctrl_q[2*g +: 2]);
    assign out_new[g] = dir_is_out(wdata[2*g +: 2]);
  end

  assign upd_en = ctrl_we | data_we;

  always_comb begin
    ctrl_d   = ctrl_q;
    stored_d = stored_q;
    latch_d  = latch_q;
    if (ctrl_we) begin
      ctrl_d  = wdata[CW-1:0];
      latch_d = stored_q & out_new;
    end else if (data_we) begin
      stored_d = wdata[W-1:0];
      latch_d  = wdata[W-1:0] & out_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      stored_q <= '0;
      latch_q  <= '0;
    end else if (upd_en) begin
      ctrl_q   <= ctrl_d;
      stored_q <= stored_d;
      latch_q  <= latch_d;
    end
  end

  assign ctrl_val = ctrl_q;
  assign rd_val   = (pin_in & in_cur) | (latch_q & out_cur);
  assign pin_out  = latch_q;
  assign pin_oe   = out_cur;
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  parameter int MAIN_W = 16,
  parameter int AUX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [MAIN_W-1:0] main_pin_in,
  output logic [MAIN_W-1:0] main_pin_out,
  output logic [MAIN_W-1:0] main_pin_oe,
  input  logic [AUX_W-1:0]  aux_pin_in,
  output logic [AUX_W-1:0]  aux_pin_out,
  output logic [AUX_W-1:0]  aux_pin_oe
);
  localparam int MCW = 2 * MAIN_W;
  localparam int ACW = 2 * AUX_W;

  logic           rst_sync_n;
  logic [3:0]     sel, we;
  logic [MCW-1:0] main_ctrl;
  logic [ACW-1:0] aux_ctrl;
  logic [MAIN_W-1:0] main_rd;
  logic [AUX_W-1:0]  aux_rd;

  pio_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pio_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
    .addr  (addr),
    .wr_en (wr_en),
    .sel   (sel),
    .we    (we)
  );

  pio_lane #(.W(MAIN_W), .DW(DW)) i_main (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ctrl_we  (we[0]),
    .data_we  (we[1]),
    .wdata    (wdata),
    .pin_in   (main_pin_in),
    .ctrl_val (main_ctrl),
    .rd_val   (main_rd),
    .pin_out  (main_pin_out),
    .pin_oe   (main_pin_oe)
  );

  pio_lane #(.W(AUX_W), .DW(DW)) i_aux (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ctrl_we  (we[2]),
    .data_we  (we[3]),
    .wdata    (wdata),
    .pin_in   (aux_pin_in),
    .ctrl_val (aux_ctrl),
    .rd_val   (aux_rd),
    .pin_out  (aux_pin_out),
    .pin_oe   (aux_pin_oe)
  );

  always_comb begin
    rdata = '0;
    unique case (1'b1)
      sel[0]:  rdata[MCW-1:0]    = main_ctrl;
      sel[1]:  rdata[MAIN_W-1:0] = main_rd;
      sel[2]:  rdata[ACW-1:0]    = aux_ctrl;
      sel[3]:  rdata[AUX_W-1:0]  = aux_rd;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  parameter int MAIN_W = 16,
  parameter int AUX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     rdata,
  input logic [MAIN_W-1:0] main_pin_out,
  input logic [MAIN_W-1:0] main_pin_oe,
  input logic [AUX_W-1:0]  aux_pin_out,
  input logic [AUX_W-1:0]  aux_pin_oe
);
  import pio_pkg::*;

  function automatic logic [MAIN_W-1:0] main_oe_of(input logic [DW-1:0] c);
    logic [MAIN_W-1:0] m;
    for (int i = 0; i < MAIN_W; i++) m[i] = c[2*i];
    return m;
  endfunction

  function automatic logic [AUX_W-1:0] aux_oe_of(input logic [DW-1:0] c);
    logic [AUX_W-1:0] m;
    for (int i = 0; i < AUX_W; i++) m[i] = c[2*i];
    return m;
  endfunction

  // R11
  out_within_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((main_pin_out & ~main_pin_oe) == '0) && ((aux_pin_out & ~aux_pin_oe) == '0));

  // R4
  ctrl_sets_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_MAIN_CTRL)) |=> main_pin_oe == main_oe_of($past(wdata)));

  // R6
  data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_MAIN_DATA)) |=>
      main_pin_out == ($past(wdata[MAIN_W-1:0]) & main_pin_oe));

  // R9
  aux_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFF_AUX_CTRL)) |=> aux_pin_oe == aux_oe_of($past(wdata)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(main_pin_out) && $stable(main_pin_oe) &&
               $stable(aux_pin_out) && $stable(aux_pin_oe));

  // R7
  read_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && addr == ADDR_W'(OFF_MAIN_DATA)) |->
      ((rdata[MAIN_W-1:0] & main_pin_oe) == main_pin_out) && ((rdata >> MAIN_W) == '0));
endmodule

bind pio_port pio_port_chk #(
  .ADDR_W(ADDR_W), .DW(DW), .MAIN_W(MAIN_W), .AUX_W(AUX_W)
) i_pio_port_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .addr         (addr),
  .wr_en        (wr_en),
  .wdata        (wdata),
  .rdata        (rdata),
  .main_pin_out (main_pin_out),
  .main_pin_oe  (main_pin_oe),
  .aux_pin_out  (aux_pin_out),
  .aux_pin_oe   (aux_pin_oe)
);

// File: tb/test_pio_port.sv
`timescale 1ns/1ps
module test_pio_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] main_pin_in = '0;
  logic [15:0] main_pin_out, main_pin_oe;
  logic [3:0]  aux_pin_in = '0;
  logic [3:0]  aux_pin_out, aux_pin_oe;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] m_ctrl, a_ctrl;
  logic [15:0] m_stored, m_latch;
  logic [3:0]  a_stored, a_latch;

  always #5 clk = ~clk;

  pio_port i_pio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .main_pin_in(main_pin_in), .main_pin_out(main_pin_out),
    .main_pin_oe(main_pin_oe), .aux_pin_in(aux_pin_in),
    .aux_pin_out(aux_pin_out), .aux_pin_oe(aux_pin_oe)
  );

  function automatic logic [15:0] omask(input logic [31:0] c, input int w);
    logic [15:0] m = '0;
    for (int i = 0; i < w; i++) m[i] = (c[2*i +: 2] == 2'b01) || (c[2*i +: 2] == 2'b11);
    return m;
  endfunction

  function automatic logic [15:0] imask(input logic [31:0] c, input int w);
    logic [15:0] m = '0;
    for (int i = 0; i < w; i++) m[i] = (c[2*i +: 2] == 2'b10);
    return m;
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_ctrl;
      4'h4: return {16'h0, (main_pin_in & imask(m_ctrl, 16)) | m_latch};
      4'h8: return {24'h0, a_ctrl[7:0]};
      4'hC: return {28'h0, (aux_pin_in & imask(a_ctrl, 4)) | a_latch};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [3:0] a, input logic [31:0] d);
    case (a)
      4'h0: begin m_ctrl = d; m_latch = m_stored & omask(d, 16); end
      4'h4: begin m_stored = d[15:0]; m_latch = d[15:0] & omask(m_ctrl, 16); end
      4'h8: begin a_ctrl = {24'h0, d[7:0]}; a_latch = a_stored & omask(d, 4)[3:0]; end
      4'hC: begin a_stored = d[3:0]; a_latch = d[3:0] & omask(a_ctrl, 4)[3:0]; end
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_chk(input logic [3:0] a, input string tag);
    logic [31:0] e;
    addr = a;
    #1;
    e = exp_read(a);
    check(rdata === e, tag, rdata, e);
  endtask

  task automatic pins_chk(input string tag);
    logic [15:0] om = omask(m_ctrl, 16);
    logic [15:0] oa = omask(a_ctrl, 4);
    check(main_pin_oe === om, {tag, " R11 main oe"}, 32'(main_pin_oe), 32'(om));
    check(main_pin_out === m_latch, {tag, " R6 main out"}, 32'(main_pin_out), 32'(m_latch));
    check(aux_pin_oe === oa[3:0], {tag, " R9 aux oe"}, 32'(aux_pin_oe), 32'(oa[3:0]));
    check(aux_pin_out === a_latch, {tag, " R9 aux out"}, 32'(aux_pin_out), 32'(a_latch));
  endtask

  task automatic all_chk(input string tag);
    pins_chk(tag);
    read_chk(4'h0, {tag, " R2 main ctrl"});
    read_chk(4'h4, {tag, " R7 main data"});
    read_chk(4'h8, {tag, " R9 aux ctrl"});
    read_chk(4'hC, {tag, " R9 aux data"});
    read_chk(4'h2, {tag, " R10 hole"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ctrl = '0; a_ctrl = '0; m_stored = '0; m_latch = '0; a_stored = '0; a_latch = '0;
    main_pin_in = 16'hFFFF; aux_pin_in = 4'hF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 and R5: reset state, pins high but every field inactive
    all_chk("R1 reset");
    check(rdata === 32'h0 && main_pin_oe === 16'h0, "R1 R5 zero", rdata, 32'h0);

    // R2: only pin 5 as output (bits [11:10] = 01)
    do_write(4'h0, 32'h0000_0400);
    check(main_pin_oe === 16'h0020, "R2 field position", 32'(main_pin_oe), 32'h20);

    // R8: store data while nothing is output, then enable all outputs
    do_write(4'h0, 32'h0);
    do_write(4'h4, 32'h0000_1234);
    check(main_pin_out === 16'h0, "R6 no outputs", 32'(main_pin_out), 32'h0);
    do_write(4'h0, 32'h5555_5555);
    check(main_pin_out === 16'h1234, "R8 rebuild latch", 32'(main_pin_out), 32'h1234);
    do_write(4'h0, 32'hFFFF_FFFF);
    check(main_pin_out === 16'h1234, "R4 code 11 output", 32'(main_pin_out), 32'h1234);

    // R3, R4, R5, R7: pin i uses code i mod 4
    do_write(4'h0, 32'hE4E4_E4E4);
    do_write(4'h4, 32'h0000_FFFF);
    check(main_pin_out === 16'hAAAA, "R6 masked write", 32'(main_pin_out), 32'hAAAA);
    main_pin_in = 16'h5555;
    addr = 4'h4; #1;
    check(rdata === 32'h0000_EEEE, "R7 merge", rdata, 32'hEEEE);
    main_pin_in = 16'h0000;
    addr = 4'h4; #1;
    check(rdata === 32'h0000_AAAA, "R3 input low", rdata, 32'hAAAA);
    all_chk("R5 mixed");

    // R10: writes to holes and upper data bits are ignored
    do_write(4'h2, 32'hFFFF_FFFF);
    do_write(4'h6, 32'hFFFF_FFFF);
    all_chk("R10 hole write");

    // R9: auxiliary port, codes 10,11,00,01 on pins 3..0
    aux_pin_in = 4'b1010;
    do_write(4'h8, 32'hFFFF_FFB1);
    do_write(4'hC, 32'hFFFF_FFFF);
    check(aux_pin_oe === 4'b0101, "R9 aux oe", 32'(aux_pin_oe), 32'h5);
    addr = 4'hC; #1;
    check(rdata === 32'h0000_000D, "R9 aux merge", rdata, 32'hD);
    all_chk("R9 aux");

    // Random stimulus
    for (int it = 0; it < 400; it++) begin
      logic [3:0] a;
      logic [31:0] d;
      int pick = $urandom_range(0, 9);
      a = (pick < 8) ? 4'(4 * (pick % 4)) : 4'($urandom_range(0, 15));
      d = $urandom();
      main_pin_in = 16'($urandom());
      aux_pin_in  = 4'($urandom());
      do_write(a, d);
      all_chk("rand");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule